// File: doc/BRIEF.md
# Display List Entry Walker

The walker follows per-channel display lists that sit in a shared, word-addressed on-chip memory. Each channel has its own start-word input. A start pulse on an active channel queues a walk. The walker then reads only the header word of each entry and uses two fields of that header. The end flag stops the walk. The size field gives the distance, in words, to the next header. Payload words between headers are never read.

Every entry that is neither an end marker nor malformed goes to a downstream consumer over a valid/ready port. The port carries the channel, the header address and the header word. Malformed lists set a sticky per-channel error flag. A list is malformed when its start pointer lies in the reserved boot region, or when a non-end header has a size of zero. When several channels are queued, they are served one at a time, lowest index first.

Top module: `dlist_walker`

## Requirements
- R1: Each of the three channels has its own start word on `base_i` (channel c at bits [8c+7:8c]). The first read of a walk for channel c is at that address.
- R2: A header with bit 31 set ends the walk. The end marker itself is not presented on the entry port.
- R3: The size field of a header is bits [7:0]. The next header is read at the current header address plus that size.
- R4: Payload words between headers are not interpreted. A payload word with bit 31 set does not stop the walk.
- R5: A start pulse for a channel whose `chan_act_i` bit is low is ignored. No entries are produced and its error flag is unchanged.
- R6: If the next header address would pass word 255, the walk ends after the current entry is delivered, and no error is raised. A header at word 255 is still read and reported.
- R7: A start pointer below word 16 (the boot region) is never read. The walk ends at once with that channel's error flag set.
- R8: A non-end header with size zero is not reported. It sets the channel's error flag and ends the walk. The flag stays set until the next accepted start pulse for that channel clears it.
- R9: While `ent_valid_o` is high and `ent_ready_i` is low, the entry outputs hold steady and nothing is lost.
- R10: Channels queued together are walked one after another, in ascending index order.
- R11: The memory has one cycle of read latency. A read is never issued in two consecutive cycles. An entry is presented two cycles after its header read.
- R12: After reset the entry port is idle, all error flags are clear, no read is issued, and `idle_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 3 | Per-channel start pulse |
| chan_act_i | input | 3 | Channel is running (not disabled, not at end of frame) |
| base_i | input | 24 | Start word per channel, 8 bits each |
| mem_rd_en_o | output | 1 | List memory read strobe |
| mem_rd_addr_o | output | 8 | List memory word address |
| mem_rd_data_i | input | 32 | Read data, valid the cycle after the strobe |
| ent_valid_o | output | 1 | Entry available |
| ent_ready_i | input | 1 | Consumer accepts entry |
| ent_chan_o | output | 2 | Channel of the entry |
| ent_addr_o | output | 8 | Header word address |
| ent_word_o | output | 32 | Header word |
| err_o | output | 3 | Sticky malformed-list flag per channel |
| idle_o | output | 1 | No walk in progress or queued |

## Verification
The checker watches, on every cycle, the properties that are local in time. These are: held entries under back-pressure, no read in consecutive cycles, no read inside the boot region, no end marker or zero-size header on the entry port, and error flags that stay set until their channel is restarted. Other behaviour depends on list contents and on the order of work. This covers the exact entry sequence, skipped payload words, the ascending service order, the address ceiling and the ignored inactive channel. A scoreboard checks this in the bench, against lists built in the bench's memory model.

// File: rtl/dlw_pkg.sv
package dlw_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_READ = 2'd1,
        ST_DATA = 2'd2,
        ST_OUT  = 2'd3
    } walk_st_e;
endpackage

// File: rtl/dlw_lowest_first.sv
module dlw_lowest_first #(
    parameter int N  = 3,
    parameter int IW = 2
) (
    input  logic [N-1:0]  req,
    output logic [IW-1:0] idx,
    output logic [N-1:0]  onehot,
    output logic          any
);
    always_comb begin
        idx    = '0;
        onehot = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                idx       = IW'(i);
                onehot    = '0;
                onehot[i] = 1'b1;
            end
        end
        any = |req;
    end
endmodule

// File: rtl/dlw_hdr_step.sv
module dlw_hdr_step #(
    parameter int AW     = 8,
    parameter int SIZE_W = 8
) (
    input  logic [AW-1:0]     cur_addr,
    input  logic [SIZE_W-1:0] size,
    output logic              size_zero,
    output logic [AW-1:0]     next_addr,
    output logic              past_limit
);
    localparam int SW = ((SIZE_W > AW) ? SIZE_W : AW) + 1;

    logic [SW-1:0] sum;

    always_comb begin
        sum        = SW'(cur_addr) + SW'(size);
        size_zero  = (size == '0);
        next_addr  = sum[AW-1:0];
        past_limit = |sum[SW-1:AW];
    end
endmodule

// File: rtl/dlist_walker.sv
module dlist_walker #(
    parameter int NCH        = 3,
    parameter int AW         = 8,
    parameter int DW         = 32,
    parameter int END_BIT    = 31,
    parameter int SIZE_LSB   = 0,
    parameter int SIZE_W     = 8,
    parameter int BOOT_WORDS = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NCH-1:0]            start_i,
    input  logic [NCH-1:0]            chan_act_i,
    input  logic [NCH*AW-1:0]         base_i,
    output logic                      mem_rd_en_o,
    output logic [AW-1:0]             mem_rd_addr_o,
    input  logic [DW-1:0]             mem_rd_data_i,
    output logic                      ent_valid_o,
    input  logic                      ent_ready_i,
    output logic [((NCH > 1) ? $clog2(NCH) : 1)-1:0] ent_chan_o,
    output logic [AW-1:0]             ent_addr_o,
    output logic [DW-1:0]             ent_word_o,
    output logic [NCH-1:0]            err_o,
    output logic                      idle_o
);
    import dlw_pkg::*;

    localparam int CW = (NCH > 1) ? $clog2(NCH) : 1;
    localparam logic [AW-1:0] BOOT_LIM = AW'(BOOT_WORDS);

    typedef struct packed {
        walk_st_e       st;
        logic [NCH-1:0] pend;
        logic [NCH-1:0] err;
        logic [CW-1:0]  chan;
        logic [AW-1:0]  addr;
        logic [DW-1:0]  hdr;
    } walk_state_t;

    walk_state_t q, d;

    // Arbitration among queued channels
    logic [CW-1:0]  pick_idx;
    logic [NCH-1:0] pick_oh;
    logic           pick_any;

    dlw_lowest_first #(.N(NCH), .IW(CW)) u_pick (
        .req    (q.pend),
        .idx    (pick_idx),
        .onehot (pick_oh),
        .any    (pick_any)
    );

    // Header fields: fresh memory data in DATA, held copy in OUT
    logic              end_sel;
    logic [SIZE_W-1:0] size_sel;
    logic              size_zero;
    logic [AW-1:0]     next_addr;
    logic              past_limit;

    always_comb begin
        if (q.st == ST_DATA) begin
            end_sel  = mem_rd_data_i[END_BIT];
            size_sel = mem_rd_data_i[SIZE_LSB +: SIZE_W];
        end else begin
            end_sel  = q.hdr[END_BIT];
            size_sel = q.hdr[SIZE_LSB +: SIZE_W];
        end
    end

    dlw_hdr_step #(.AW(AW), .SIZE_W(SIZE_W)) u_step (
        .cur_addr   (q.addr),
        .size       (size_sel),
        .size_zero  (size_zero),
        .next_addr  (next_addr),
        .past_limit (past_limit)
    );

    logic [NCH-1:0] accept;
    logic [AW-1:0]  pick_base;

    always_comb begin
        d         = q;
        accept    = start_i & chan_act_i;
        pick_base = base_i[pick_idx*AW +: AW];
        d.pend    = q.pend | accept;
        d.err     = q.err & ~accept;

        case (q.st)
            ST_IDLE: begin
                if (pick_any) begin
                    d.pend = (q.pend & ~pick_oh) | accept;
                    d.chan = pick_idx;
                    if (pick_base < BOOT_LIM) begin
                        d.err[pick_idx] = 1'b1;
                    end else begin
                        d.addr = pick_base;
                        d.st   = ST_READ;
                    end
                end
            end
            ST_READ: begin
                d.st = ST_DATA;
            end
            ST_DATA: begin
                if (end_sel) begin
                    d.st = ST_IDLE;
                end else if (size_zero) begin
                    d.err[q.chan] = 1'b1;
                    d.st          = ST_IDLE;
                end else begin
                    d.hdr = mem_rd_data_i;
                    d.st  = ST_OUT;
                end
            end
            ST_OUT: begin
                if (ent_ready_i) begin
                    if (past_limit) begin
                        d.st = ST_IDLE;
                    end else begin
                        d.addr = next_addr;
                        d.st   = ST_READ;
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.st   <= ST_IDLE;
            q.pend <= '0;
            q.err  <= '0;
            q.chan <= '0;
            q.addr <= '0;
            q.hdr  <= '0;
        end else begin
            q <= d;
        end
    end

    assign mem_rd_en_o   = (q.st == ST_READ);
    assign mem_rd_addr_o = q.addr;
    assign ent_valid_o   = (q.st == ST_OUT);
    assign ent_chan_o    = q.chan;
    assign ent_addr_o    = q.addr;
    assign ent_word_o    = q.hdr;
    assign err_o         = q.err;
    assign idle_o        = (q.st == ST_IDLE) && (q.pend == '0);
endmodule

// File: rtl/dlw_checker.sv
module dlw_checker #(
    parameter int NCH        = 3,
    parameter int AW         = 8,
    parameter int DW         = 32,
    parameter int END_BIT    = 31,
    parameter int SIZE_LSB   = 0,
    parameter int SIZE_W     = 8,
    parameter int BOOT_WORDS = 16,
    parameter int CW         = 2
) (
    input logic           clk,
    input logic           rst_n,
    input logic [NCH-1:0] start_i,
    input logic           mem_rd_en_o,
    input logic [AW-1:0]  mem_rd_addr_o,
    input logic           ent_valid_o,
    input logic           ent_ready_i,
    input logic [CW-1:0]  ent_chan_o,
    input logic [AW-1:0]  ent_addr_o,
    input logic [DW-1:0]  ent_word_o,
    input logic [NCH-1:0] err_o
);
    p_hold_under_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ent_valid_o && !ent_ready_i) |=>
        (ent_valid_o && $stable(ent_word_o) && $stable(ent_addr_o) && $stable(ent_chan_o)));

    p_no_back_to_back_read_r11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en_o |=> !mem_rd_en_o);

    p_boot_region_untouched_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en_o |-> (mem_rd_addr_o >= AW'(BOOT_WORDS)));

    p_end_marker_hidden_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ent_valid_o |-> !ent_word_o[END_BIT]);

    p_zero_size_hidden_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ent_valid_o |-> (ent_word_o[SIZE_LSB +: SIZE_W] != '0));

    generate
        for (genvar c = 0; c < NCH; c++) begin : g_sticky
            p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
                (err_o[c] && !start_i[c]) |=> err_o[c]);
        end
    endgenerate
endmodule

bind dlist_walker dlw_checker #(
    .NCH(NCH), .AW(AW), .DW(DW), .END_BIT(END_BIT), .SIZE_LSB(SIZE_LSB),
    .SIZE_W(SIZE_W), .BOOT_WORDS(BOOT_WORDS), .CW(CW)
) u_dlw_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_i       (start_i),
    .mem_rd_en_o   (mem_rd_en_o),
    .mem_rd_addr_o (mem_rd_addr_o),
    .ent_valid_o   (ent_valid_o),
    .ent_ready_i   (ent_ready_i),
    .ent_chan_o    (ent_chan_o),
    .ent_addr_o    (ent_addr_o),
    .ent_word_o    (ent_word_o),
    .err_o         (err_o)
);

// File: tb/dlist_walker_test.sv
module dlist_walker_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  start_i = '0;
    logic [2:0]  chan_act_i = 3'b111;
    logic [23:0] base_i = '0;
    logic        mem_rd_en_o;
    logic [7:0]  mem_rd_addr_o;
    logic [31:0] mem_rd_data_i;
    logic        ent_valid_o;
    logic        ent_ready_i = 1'b0;
    logic [1:0]  ent_chan_o;
    logic [7:0]  ent_addr_o;
    logic [31:0] ent_word_o;
    logic [2:0]  err_o;
    logic        idle_o;

    always #4 clk = ~clk;

    dlist_walker uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .chan_act_i(chan_act_i),
        .base_i(base_i), .mem_rd_en_o(mem_rd_en_o), .mem_rd_addr_o(mem_rd_addr_o),
        .mem_rd_data_i(mem_rd_data_i), .ent_valid_o(ent_valid_o),
        .ent_ready_i(ent_ready_i), .ent_chan_o(ent_chan_o), .ent_addr_o(ent_addr_o),
        .ent_word_o(ent_word_o), .err_o(err_o), .idle_o(idle_o)
    );

    logic [31:0] mem [256];
    always_ff @(posedge clk) if (mem_rd_en_o) mem_rd_data_i <= mem[mem_rd_addr_o];

    int checks = 0;
    int errors = 0;
    logic [41:0] exp_q [$];
    bit hold_low = 1'b0;
    int tick = 0;

    task automatic check(bit ok, string req, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Consumer readiness pattern, changed just after each rising edge
    always @(posedge clk) begin
        #1;
        tick++;
        ent_ready_i = hold_low ? 1'b0 : ((tick % 3) != 1);
    end

    // Monitor: pops one expected entry per accepted handshake
    always @(negedge clk) begin
        if (rst_n && ent_valid_o && ent_ready_i) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R2/R3", "unexpected entry", {ent_chan_o, ent_addr_o, ent_word_o}, 0);
            end else begin
                logic [41:0] e;
                e = exp_q.pop_front();
                check({ent_chan_o, ent_addr_o, ent_word_o} == e, "R3/R4/R10",
                      "entry chan/addr/word", {ent_chan_o, ent_addr_o, ent_word_o}, e);
            end
        end
    end

    // Independent model of a walk, built from the requirements
    task automatic model_walk(int ch, int base, output bit e);
        int a;
        logic [31:0] w;
        e = 1'b0;
        a = base;
        if (a < 16) begin
            e = 1'b1;
            return;
        end
        while (1) begin
            w = mem[a];
            if (w[31]) break;
            if (w[7:0] == 8'd0) begin
                e = 1'b1;
                break;
            end
            exp_q.push_back({2'(ch), 8'(a), w});
            if (a + int'(w[7:0]) > 255) break;
            a = a + int'(w[7:0]);
        end
    endtask

    task automatic pulse(logic [2:0] m);
        @(posedge clk); #1 start_i = m;
        @(posedge clk); #1 start_i = '0;
    endtask

    task automatic wait_idle();
        for (int k = 0; k < 3000; k++) begin
            @(negedge clk);
            if (idle_o && !ent_valid_o) break;
        end
        @(negedge clk);
    endtask

    task automatic set_base(int ch, int b);
        base_i[ch*8 +: 8] = 8'(b);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        bit e0, e1, e2;
        logic [41:0] snap;
        for (int i = 0; i < 256; i++) mem[i] = 32'h8000_0000;
        // channel 0 list at 16: payload word 17 and 21 carry bit 31
        mem[16] = 32'h0000_5504; mem[17] = 32'h8000_0000;
        mem[18] = 32'h0000_0000; mem[19] = 32'h1234_0000;
        mem[20] = 32'h0000_1203; mem[21] = 32'h8000_0001; mem[22] = 32'h0;
        mem[23] = 32'h8000_0000;
        // channel 2 list at 40 with a zero-size header at 42
        mem[40] = 32'h0000_AA02; mem[41] = 32'h8000_0000; mem[42] = 32'h0000_7700;
        mem[60] = 32'h8000_0000;
        set_base(0, 16); set_base(1, 60); set_base(2, 40);

        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check(ent_valid_o == 1'b0, "R12", "valid after reset", ent_valid_o, 0);
        check(err_o == 3'b000, "R12", "err after reset", err_o, 0);
        check(mem_rd_en_o == 1'b0, "R12", "read after reset", mem_rd_en_o, 0);
        check(idle_o == 1'b1, "R12", "idle after reset", idle_o, 1);

        // R1 R2 R3 R4: single channel walk with trap payload
        model_walk(0, 16, e0);
        pulse(3'b001);
        wait_idle();
        check(exp_q.size() == 0, "R4", "entries outstanding ch0", exp_q.size(), 0);
        check(err_o == 3'b000, "R2", "err after clean walk", err_o, 0);

        // R10 R5 R8: all started together, channel 1 inactive
        chan_act_i = 3'b101;
        model_walk(0, 16, e0);
        model_walk(2, 40, e2);
        pulse(3'b111);
        wait_idle();
        chan_act_i = 3'b111;
        check(exp_q.size() == 0, "R10", "entries outstanding ascending", exp_q.size(), 0);
        check(err_o[2] == e2 && e2, "R8", "zero-size error ch2", err_o[2], 1);
        check(err_o[1] == 1'b0, "R5", "inactive ch1 err", err_o[1], 0);
        check(err_o[0] == 1'b0, "R8", "ch0 untouched err", err_o[0], 0);
        repeat (5) @(negedge clk);
        check(err_o[2] == 1'b1, "R8", "error held while idle", err_o[2], 1);

        // R11 R9: ch2 restarted on a good list under back-pressure
        mem[48] = 32'h0000_0101; mem[49] = 32'h8000_0000;
        set_base(2, 48);
        hold_low = 1'b1;
        model_walk(2, 48, e2);
        pulse(3'b100);
        check(err_o[2] == 1'b0, "R8", "error cleared by start", err_o[2], 0);
        for (int k = 0; k < 20; k++) begin
            if (mem_rd_en_o) break;
            @(negedge clk);
        end
        check(mem_rd_en_o && mem_rd_addr_o == 8'd48, "R1", "first read address ch2", mem_rd_addr_o, 48);
        @(negedge clk);
        check(mem_rd_en_o == 1'b0, "R11", "no read in next cycle", mem_rd_en_o, 0);
        check(ent_valid_o == 1'b0, "R11", "valid one cycle after read", ent_valid_o, 0);
        @(negedge clk);
        check(ent_valid_o == 1'b1, "R11", "valid two cycles after read", ent_valid_o, 1);
        snap = {ent_chan_o, ent_addr_o, ent_word_o};
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            check(ent_valid_o && {ent_chan_o, ent_addr_o, ent_word_o} == snap, "R9",
                  "entry held under stall", {ent_chan_o, ent_addr_o, ent_word_o}, snap);
        end
        hold_low = 1'b0;
        wait_idle();
        check(exp_q.size() == 0, "R9", "stalled entry delivered", exp_q.size(), 0);

        // R7: start pointer inside the boot region
        set_base(1, 5);
        pulse(3'b010);
        wait_idle();
        check(err_o[1] == 1'b1, "R7", "boot region error", err_o[1], 1);
        check(exp_q.size() == 0, "R7", "no entries from boot start", exp_q.size(), 0);

        // R6: address ceiling
        mem[250] = 32'h0000_0003; mem[253] = 32'h0000_0004;
        model_walk(0, 250, e0);
        set_base(0, 250);
        pulse(3'b001);
        wait_idle();
        check(exp_q.size() == 0, "R6", "entries before ceiling", exp_q.size(), 0);
        check(err_o[0] == 1'b0, "R6", "no error at ceiling", err_o[0], 0);
        mem[252] = 32'h0000_0003; mem[255] = 32'h0000_0005;
        model_walk(0, 252, e0);
        check(exp_q.size() == 2, "R6", "model entries incl. word 255", exp_q.size(), 2);
        set_base(0, 252);
        pulse(3'b001);
        wait_idle();
        check(exp_q.size() == 0, "R6", "header at word 255 reported", exp_q.size(), 0);
        check(err_o[0] == 1'b0, "R6", "no error after word 255", err_o[0], 0);

        // R5: inactive channel start leaves error flag as it was
        chan_act_i = 3'b101;
        set_base(1, 16);
        pulse(3'b010);
        repeat (10) @(negedge clk);
        check(err_o[1] == 1'b1 && idle_o, "R5", "ignored start keeps err and idle", {err_o[1], idle_o}, 2'b11);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule